// File: doc/BRIEF.md
# SPI Read Address Pointer Engine

This block is the read side of an SPI slave that serves a 9-bit address space holding a byte memory, a pair of port-read addresses and a window of clock/calendar registers. The master lowers chip select and sends an instruction byte. Bit 3 of that byte is the top address bit. The master then sends the low address byte. The slave answers with a status byte, followed by one data byte per eight SCK periods for as long as chip select stays low.

Reads follow special pointer rules. Clock registers are served from a shadow copy that is taken once per transfer. A start address in the port region keeps the pointer moving back and forth between the two port addresses. An address with nothing behind it reads as 00h. The SPI pins are oversampled in the system clock domain, and the output pin and its enable are registered. The memory is a synchronous array with a plain write port, which is used to load it.

Top module: `spi_rd_engine`

## Requirements
- R1: After reset, and while chip select is high, `spi_miso_oe` is 0. Raising chip select at any point ends the transfer, and the next selection starts again at the instruction byte.
- R2: A byte is accepted as the read instruction when bits 7..4 are 0000 and bits 2..0 are 011. Bit 3 becomes address bit 8. Any other first byte yields no output, and `spi_miso_oe` stays 0 until deselect.
- R3: The eight bits after the instruction are address bits 7..0. The first byte returned is `status_byte`. Its MSB appears on the falling SCK edge after the 16th rising edge.
- R4: Each byte is sent MSB first, with one new bit per falling SCK edge. MOSI is sampled on rising edges.
- R5: Addresses 000h..0FFh return the memory contents, and consecutive bytes come from consecutive addresses.
- R6: Addresses not backed by memory, port or clock window (for example 100h..125h, 130h..135h and 136h..1FFh) return 00h. The pointer keeps incrementing, and past 1FFh it reaches 000h, where valid data resumes.
- R7: After address 135h the pointer goes to 000h.
- R8: A start address of 126h or 127h makes the pointer alternate between them after every byte. Address 126h returns `pio_lo`, and 127h returns {0000, `pio_hi`}.
- R9: The window 128h..12Fh returns a snapshot of `rtc_live` (byte n at bits 8n+7..8n) taken on the rising edge that carries address bit 0. Changes to `rtc_live` later in the same transfer are not seen.
- R10: `spi_miso_oe` rises once the address byte is complete and stays high until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Drive enable for the data-out pad |
| status_byte | input | 8 | Byte returned first in each read |
| pio_lo | input | 8 | Port bits 7..0 |
| pio_hi | input | 4 | Port bits 11..8 |
| rtc_live | input | 8*RTC_BYTES | Live clock/calendar bytes |
| mem_we | input | 1 | Memory load write enable |
| mem_waddr | input | log2(MEM_DEPTH) | Memory load address |
| mem_wdata | input | 8 | Memory load data |

## Verification
Every SPI pin passes a two-flop synchronizer and an edge register. A pin edge therefore acts about three system clocks later, and the output bit is registered in that same cycle. Memory data and the port snapshot need two more clocks to reach the byte-select register, which must be ready before the next falling SCK edge. For this reason the bench holds each SCK level for eight system clocks and reads MISO at the bench's own rising SCK edge, in mode-0 fashion. Expected bytes are queued by the driver before each transfer, and a monitor pops them as each eighth data bit arrives. After deselect the bench checks that the queue is empty and that the enable has dropped.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA, PH_SKIP} phase_t;

  function automatic logic is_read_cmd(input logic [7:0] b);
    return (b[7:4] == 4'b0000) && (b[2:0] == 3'b011);
  endfunction
endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {3{INIT}};
    else     sh <= {sh[1:0], d};
  end

  assign lvl  = sh[1];
  assign rise = sh[1] & ~sh[2];
  assign fall = ~sh[1] & sh[2];
endmodule

// File: rtl/spi_rd_mem.sv
module spi_rd_mem #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/spi_rd_ptr.sv
module spi_rd_ptr #(
  parameter logic [8:0] LAST_ADDR   = 9'h135,
  parameter logic [8:0] PIO_LO_ADDR = 9'h126
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [8:0] start,
  input  logic       adv,
  output logic [8:0] ptr,
  output logic       toggle
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      toggle <= 1'b0;
    end else if (load) begin
      ptr    <= start;
      toggle <= (start[8:1] == PIO_LO_ADDR[8:1]);
    end else if (adv) begin
      if (toggle)                 ptr <= {ptr[8:1], ~ptr[0]};
      else if (ptr == LAST_ADDR)  ptr <= '0;
      else                        ptr <= ptr + 9'd1;
    end
  end

  // R8: alternating mode never leaves the port pair
  a_r8_toggle_pair: assert property (@(posedge clk) disable iff (rst)
    toggle |-> (ptr[8:1] == PIO_LO_ADDR[8:1]));

  // R7: last mapped address is followed by 000h
  a_r7_wrap_last: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && !toggle && ptr == LAST_ADDR) |=> (ptr == 9'h000));
endmodule

// File: rtl/spi_rd_engine.sv
module spi_rd_engine
  import spi_rd_pkg::*;
#(
  parameter int         MEM_DEPTH   = 256,
  parameter logic [8:0] LAST_ADDR   = 9'h135,
  parameter logic [8:0] PIO_LO_ADDR = 9'h126,
  parameter logic [8:0] RTC_BASE    = 9'h128,
  parameter int         RTC_BYTES   = 8,
  localparam int        MEM_AW      = $clog2(MEM_DEPTH),
  localparam int        RTC_AW      = (RTC_BYTES > 1) ? $clog2(RTC_BYTES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   spi_sck,
  input  logic                   spi_csn,
  input  logic                   spi_mosi,
  output logic                   spi_miso,
  output logic                   spi_miso_oe,
  input  logic [7:0]             status_byte,
  input  logic [7:0]             pio_lo,
  input  logic [3:0]             pio_hi,
  input  logic [RTC_BYTES*8-1:0] rtc_live,
  input  logic                   mem_we,
  input  logic [MEM_AW-1:0]      mem_waddr,
  input  logic [7:0]             mem_wdata
);
  localparam logic [9:0] MEM_END = 10'(MEM_DEPTH);
  localparam logic [9:0] RTC_END = 10'(RTC_BASE) + 10'(RTC_BYTES);

  logic sck_l, sck_rise, sck_fall;
  logic csn_l, csn_rise, csn_fall;
  logic mosi_l, mosi_rise, mosi_fall;

  spi_rd_sync #(.INIT(1'b0)) u_sck  (.clk, .rst, .d(spi_sck),
    .lvl(sck_l), .rise(sck_rise), .fall(sck_fall));
  spi_rd_sync #(.INIT(1'b1)) u_csn  (.clk, .rst, .d(spi_csn),
    .lvl(csn_l), .rise(csn_rise), .fall(csn_fall));
  spi_rd_sync #(.INIT(1'b0)) u_mosi (.clk, .rst, .d(spi_mosi),
    .lvl(mosi_l), .rise(mosi_rise), .fall(mosi_fall));

  phase_t     phase;
  logic [2:0] icnt, ocnt;
  logic [6:0] ishift;
  logic [7:0] oshift, nb, out_src, mem_q;
  logic       first_out, a8;
  logic [7:0] pio_lo_s;
  logic [3:0] pio_hi_s;
  logic [7:0] rtc_sh [RTC_BYTES];
  logic [8:0] ptr, ptr_q;
  logic       toggle;

  wire [7:0] ibyte    = {ishift, mosi_l};
  wire       addr_end = sck_rise && phase == PH_ADDR && icnt == 3'd7;
  wire       load_out = sck_fall && phase == PH_DATA && ocnt == 3'd0;
  wire       adv      = load_out && !first_out;

  spi_rd_ptr #(.LAST_ADDR(LAST_ADDR), .PIO_LO_ADDR(PIO_LO_ADDR)) u_ptr (
    .clk, .rst, .load(addr_end), .start({a8, ibyte}), .adv, .ptr, .toggle);

  spi_rd_mem #(.DEPTH(MEM_DEPTH)) u_mem (
    .clk, .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr[MEM_AW-1:0]), .rdata(mem_q));

  // Shadow copy of the clock registers, taken with address bit 0
  for (genvar g = 0; g < RTC_BYTES; g++) begin : g_shadow
    always_ff @(posedge clk) begin
      if (rst)           rtc_sh[g] <= '0;
      else if (addr_end) rtc_sh[g] <= rtc_live[g*8 +: 8];
    end
  end

  // Input shift, address bit 8 and port sampling
  always_ff @(posedge clk) begin
    if (rst) begin
      ishift   <= '0;
      a8       <= 1'b0;
      pio_lo_s <= '0;
      pio_hi_s <= '0;
    end else if (sck_rise && !csn_l) begin
      ishift <= ibyte[6:0];
      if (phase == PH_CMD && icnt == 3'd7) a8 <= ibyte[3];
      if (phase == PH_DATA && ocnt == 3'd0) begin
        pio_lo_s <= pio_lo;
        pio_hi_s <= pio_hi;
      end
    end
  end

  // Byte selection, aligned with the registered memory read
  logic [RTC_AW-1:0] ridx;
  assign ridx = RTC_AW'(ptr_q - RTC_BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      nb    <= '0;
    end else begin
      ptr_q <= ptr;
      if ({1'b0, ptr_q} < MEM_END)                    nb <= mem_q;
      else if (ptr_q == PIO_LO_ADDR)                  nb <= pio_lo_s;
      else if (ptr_q == {PIO_LO_ADDR[8:1], 1'b1})     nb <= {4'b0000, pio_hi_s};
      else if (ptr_q >= RTC_BASE && {1'b0, ptr_q} < RTC_END) nb <= rtc_sh[ridx];
      else                                            nb <= 8'h00;
    end
  end

  assign out_src = first_out ? status_byte : nb;

  // Transfer sequencing and output shifting
  always_ff @(posedge clk) begin
    if (rst || csn_l) begin
      phase       <= PH_CMD;
      icnt        <= '0;
      ocnt        <= '0;
      oshift      <= '0;
      first_out   <= 1'b1;
      spi_miso    <= 1'b0;
      spi_miso_oe <= 1'b0;
    end else begin
      if (sck_rise && (phase == PH_CMD || phase == PH_ADDR)) begin
        icnt <= icnt + 3'd1;
        if (icnt == 3'd7) begin
          if (phase == PH_ADDR) begin
            phase       <= PH_DATA;
            spi_miso_oe <= 1'b1;
          end else if (is_read_cmd(ibyte)) begin
            phase <= PH_ADDR;
          end else begin
            phase <= PH_SKIP;
          end
        end
      end
      if (sck_fall && phase == PH_DATA) begin
        ocnt <= ocnt + 3'd1;
        if (ocnt == 3'd0) begin
          spi_miso  <= out_src[7];
          oshift    <= {out_src[6:0], 1'b0};
          first_out <= 1'b0;
        end else begin
          spi_miso <= oshift[7];
          oshift   <= {oshift[6:0], 1'b0};
        end
      end
    end
  end

  // R1: deselect forces the pad enable low
  a_r1_oe_off_deselected: assert property (@(posedge clk) disable iff (rst)
    csn_l |=> !spi_miso_oe);

  // R10: enable only rises at the end of the address byte
  a_r10_oe_after_addr: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_miso_oe) |-> ($past(phase) == PH_ADDR));

  // R2: a rejected instruction keeps the pad quiet
  a_r2_skip_silent: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP) |-> !spi_miso_oe);

  // R3: first bit after the address is the status MSB
  a_r3_status_first: assert property (@(posedge clk) disable iff (rst)
    (load_out && first_out && !csn_l) |=> (spi_miso == $past(status_byte[7])));

  // R6: an address above the map selects a zero byte
  a_r6_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (ptr_q > LAST_ADDR && $stable(ptr_q)) |=> (nb == 8'h00));
endmodule

// File: tb/spi_rd_engine_test.sv
module spi_rd_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso, spi_miso_oe;
  logic [7:0]  status_byte = 8'h3C;
  logic [7:0]  pio_lo = 8'hA5;
  logic [3:0]  pio_hi = 4'hC;
  logic [63:0] rtc_live;
  logic        mem_we = 1'b0;
  logic [7:0]  mem_waddr = '0, mem_wdata = '0;

  int total = 0, bad = 0, mcnt = 0;
  logic [7:0] mbyte = '0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_rd_engine uut (.*);

  function automatic logic [7:0] mexp(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  function automatic logic [63:0] rtc_pat(input logic [7:0] base);
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = base + 8'(i);
    return v;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  // Monitor: assemble bits after the address phase and compare with the queue
  always @(negedge spi_csn) mcnt = 0;
  always @(posedge spi_sck) begin
    if (!spi_csn) begin
      if (mcnt >= 16) begin
        mbyte = {mbyte[6:0], spi_miso};
        if (((mcnt - 16) % 8) == 7) begin
          if (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(mbyte == e, t, mbyte, e);
          end else if (spi_miso_oe) begin
            chk(1'b0, "R2 unexpected byte", mbyte, 0);
          end
        end
      end
      mcnt = mcnt + 1;
    end
  end

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] addr, input int nbits,
                      input logic exp_oe, input logic bump);
    logic [15:0] hdr;
    hdr = {cmd, addr};
    @(negedge clk) spi_csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      spi_sck  = 1'b0;
      spi_mosi = (i < 16) ? hdr[15 - i] : 1'b0;
      if (bump && i == 18) rtc_live = rtc_pat(8'h80);
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    chk(spi_miso_oe == exp_oe, "R10 enable during transfer", spi_miso_oe, exp_oe);
    spi_sck = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (8) @(negedge clk);
    chk(spi_miso_oe == 1'b0, "R1 enable after deselect", spi_miso_oe, 0);
    chk(exp_q.size() == 0, "R1 missing bytes", exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rtc_live = rtc_pat(8'h10);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(spi_miso_oe == 1'b0, "R1 reset enable", spi_miso_oe, 0);
    chk(spi_miso == 1'b0, "R1 reset data", spi_miso, 0);

    for (int i = 0; i < 256; i++) begin
      mem_we = 1'b1; mem_waddr = 8'(i); mem_wdata = mexp(i);
      @(negedge clk);
    end
    mem_we = 1'b0;
    repeat (4) @(negedge clk);

    // R3 R4 R5: status then consecutive memory
    push(8'h3C, "R3 status"); push(mexp(16'h10), "R5 mem 010");
    push(mexp(16'h11), "R5 mem 011"); push(mexp(16'h12), "R4 mem 012");
    xfer(8'h03, 8'h10, 16 + 32, 1'b1, 1'b0);

    // R6: running off the memory into unmapped space
    status_byte = 8'hC3;
    push(8'hC3, "R3 status"); push(mexp(16'hFE), "R5 mem 0FE");
    push(mexp(16'hFF), "R5 mem 0FF"); push(8'h00, "R6 gap 100");
    xfer(8'h03, 8'hFE, 16 + 32, 1'b1, 1'b0);

    // R7: 134h, 135h then wrap to 000h
    push(8'hC3, "R3 status"); push(8'h00, "R6 gap 134"); push(8'h00, "R6 gap 135");
    push(mexp(0), "R7 wrap 000"); push(mexp(1), "R7 wrap 001");
    xfer(8'h0B, 8'h34, 16 + 40, 1'b1, 1'b0);

    // R6: nonexistent space until natural wrap
    push(8'hC3, "R3 status"); push(8'h00, "R6 none 1FE"); push(8'h00, "R6 none 1FF");
    push(mexp(0), "R6 resume 000");
    xfer(8'h0B, 8'hFE, 16 + 32, 1'b1, 1'b0);

    // R8: port toggling from 126h and from 127h
    push(8'hC3, "R3 status"); push(8'hA5, "R8 port 126"); push(8'h0C, "R8 port 127");
    push(8'hA5, "R8 port 126 again"); push(8'h0C, "R8 port 127 again");
    xfer(8'h0B, 8'h26, 16 + 40, 1'b1, 1'b0);
    pio_lo = 8'h3E; pio_hi = 4'h7;
    push(8'hC3, "R3 status"); push(8'h07, "R8 port 127"); push(8'h3E, "R8 port 126");
    push(8'h07, "R8 port 127 again");
    xfer(8'h0B, 8'h27, 16 + 32, 1'b1, 1'b0);

    // R9: snapshot held although live values change mid-transfer
    push(8'hC3, "R3 status"); push(8'h10, "R9 clk 128"); push(8'h11, "R9 clk 129");
    push(8'h12, "R9 clk 12A"); push(8'h13, "R9 clk 12B");
    xfer(8'h0B, 8'h28, 16 + 40, 1'b1, 1'b1);
    push(8'hC3, "R3 status"); push(8'h86, "R9 clk 12E new"); push(8'h87, "R9 clk 12F new");
    push(8'h00, "R6 gap 130");
    xfer(8'h0B, 8'h2E, 16 + 32, 1'b1, 1'b0);

    // R2: rejected instruction, upper nibble set
    xfer(8'h13, 8'h10, 16 + 16, 1'b0, 1'b0);
    chk(spi_miso_oe == 1'b0, "R2 rejected stays off", spi_miso_oe, 0);

    // R1: abort mid-byte, then a clean restart
    push(8'hC3, "R3 status before abort");
    xfer(8'h03, 8'h40, 16 + 12, 1'b1, 1'b0);
    push(8'hC3, "R1 restart status"); push(mexp(16'h20), "R1 restart mem 020");
    xfer(8'h03, 8'h20, 16 + 16, 1'b1, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule